// File: doc/BRIEF.md
# Scanout Position Normalizer

This block turns a raw raster counter reading into a signed scanout position measured from the end of vertical blank. It accepts one request at a time. Each request carries the counter value, the counting mode and the timing of the current video mode. Back on the result side it returns a vertical position, a horizontal position and a flag that marks vertical blank. Positions inside vertical blank are negative and count up to zero at the blank end line. Outside blank they count up from zero.

Two kinds of counter are supported. A line counter lags the true line by a configured offset, and the block adds that offset back and wraps it at the frame height. A pixel counter counts pixels from the start of the frame. That count is clamped to the frame, shifted by the distance from the horizontal sync edge to the line end, and then split into a line and a pixel by a sequential divider. A line reading of zero can be replaced by re-sampling a live line input, because some counters read zero just before vertical blank.

Both sides are valid/ready. A request is taken on a clock edge where `in_valid` and `in_ready` are both high, and all request fields are sampled at that edge. `in_ready` stays low until the result has been taken. The result is offered with `out_valid` and stays unchanged while `out_ready` is low. It is consumed on an edge where both are high. Holding `out_ready` low stalls the block for as long as it stays low.

Top module: `scanpos_normalizer`

## Requirements
- R1: `in_ready` is high only while no request is in flight and no result is pending. After reset `in_ready` is 1 and `out_valid` is 0. A result whose `out_valid` is high with `out_ready` low keeps `out_vpos`, `out_hpos` and `out_in_vblank` unchanged on the next cycle.
- R2: In line mode (`in_pixel_mode` = 0) the line is (low LINE_W bits of `in_raw` + `in_line_offset`) modulo `in_vtotal`.
- R3: The position is re-based against vertical blank. At or past `in_vblank_start` it is position − `in_vblank_end`. Below it, it is position + `in_vtotal` − `in_vblank_end`. In pixel mode all three timing values are first multiplied by `in_htotal`.
- R4: In line mode `out_vpos` is the re-based line and `out_hpos` is 0.
- R5: In pixel mode (`in_pixel_mode` = 1) the raw count is clamped to at most `in_vtotal`×`in_htotal` − 1.
- R6: In pixel mode, `in_htotal` − `in_hsync_start` is added to the clamped count, and the sum is taken modulo `in_vtotal`×`in_htotal` before re-basing.
- R7: In pixel mode, `out_vpos` is the re-based pixel position divided by `in_htotal` with truncation toward zero. `out_hpos` is the remainder and carries the sign of the dividend.
- R8: `out_in_vblank` is 1 exactly when `out_vpos` is negative.
- R9: In line mode with `in_zero_retry` = 1 and a raw line of 0, the block samples `live_line` once per cycle for at most RETRY_MAX cycles. It uses the first nonzero sample, or 0 if none is seen. In pixel mode `in_zero_retry` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Block can take a request |
| in_pixel_mode | input | 1 | 1: pixel counter, 0: line counter |
| in_raw | input | LINE_W+HPIX_W | Raw counter reading |
| in_zero_retry | input | 1 | Re-sample a zero line reading |
| in_line_offset | input | LINE_W | Line counter lag |
| in_htotal | input | HPIX_W | Pixels per line |
| in_hsync_start | input | HPIX_W | Pixel where horizontal sync starts |
| in_vtotal | input | LINE_W | Lines per frame |
| in_vblank_start | input | LINE_W | First blank line |
| in_vblank_end | input | LINE_W | Line where blank ends |
| live_line | input | LINE_W | Live line counter used for re-sampling |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes result |
| out_vpos | output | LINE_W+HPIX_W+2 | Signed vertical position |
| out_hpos | output | HPIX_W+1 | Signed horizontal position |
| out_in_vblank | output | 1 | Position lies in vertical blank |

## Verification
The assertions and the arithmetic assume legal mode timing. That means nonzero `in_htotal` and `in_vtotal`, `in_hsync_start` ≤ `in_htotal`, both blank lines ≤ `in_vtotal`, and in line mode a raw line and an offset each below `in_vtotal`. Under illegal timing the divider identity and the range checks would not hold. The stimulus uses one legal frame geometry and sweeps line readings only over 0 to `in_vtotal` − 1. Pixel readings are swept past the frame end on purpose, because clamping them is required behaviour.

// File: rtl/snp_pkg.sv
package snp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RETRY,
    ST_CALC,
    ST_DIV,
    ST_OUT
  } snp_state_e;
endpackage

// File: rtl/snp_rebase.sv
module snp_rebase #(
  parameter int LINE_W = 13,
  parameter int HPIX_W = 13
) (
  input  logic                             pixel_mode,
  input  logic [LINE_W+HPIX_W-1:0]         raw,
  input  logic [HPIX_W-1:0]                htotal,
  input  logic [HPIX_W-1:0]                hsync_start,
  input  logic [LINE_W-1:0]                vtotal,
  input  logic [LINE_W-1:0]                vblank_start,
  input  logic [LINE_W-1:0]                vblank_end,
  input  logic [LINE_W-1:0]                line_offset,
  output logic signed [LINE_W+HPIX_W+1:0]  pos
);
  localparam int PW = LINE_W + HPIX_W;

  logic [PW-1:0]     vt_px, vbs_px, vbe_px, last_px, clamp_px;
  logic [HPIX_W-1:0] hskew;
  logic [PW:0]       skew_sum;
  logic [LINE_W:0]   line_sum;
  logic [PW-1:0]     u, tot, st, en;

  assign vt_px   = PW'(vtotal) * PW'(htotal);
  assign vbs_px  = PW'(vblank_start) * PW'(htotal);
  assign vbe_px  = PW'(vblank_end) * PW'(htotal);
  assign last_px = vt_px - PW'(1);
  assign hskew   = htotal - hsync_start;

  always_comb begin
    // line counter: undo the fixed lag, wrap once at frame height
    line_sum = {1'b0, raw[LINE_W-1:0]} + {1'b0, line_offset};
    if (line_sum >= {1'b0, vtotal}) line_sum = line_sum - {1'b0, vtotal};
    // pixel counter: clamp, then move line start from sync edge to active edge
    clamp_px = (raw > last_px) ? last_px : raw;
    skew_sum = {1'b0, clamp_px} + {1'b0, PW'(hskew)};
    if (skew_sum >= {1'b0, vt_px}) skew_sum = skew_sum - {1'b0, vt_px};
    if (pixel_mode) begin
      u = skew_sum[PW-1:0]; tot = vt_px; st = vbs_px; en = vbe_px;
    end else begin
      u = PW'(line_sum); tot = PW'(vtotal); st = PW'(vblank_start); en = PW'(vblank_end);
    end
    if (u >= st) pos = $signed({2'b00, u}) - $signed({2'b00, en});
    else         pos = $signed({2'b00, u}) + $signed({2'b00, tot}) - $signed({2'b00, en});
  end
endmodule

// File: rtl/snp_divider.sv
module snp_divider #(
  parameter int W  = 27,
  parameter int DW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  dividend,
  input  logic [DW-1:0] divisor,
  output logic          done,
  output logic [W-1:0]  quot,
  output logic [DW-1:0] rem
);
  localparam int CW = $clog2(W + 1);
  localparam int XW = W + DW + 1;

  logic [W-1:0]  q_r, dvd_r;
  logic [DW:0]   r_r, trial;
  logic [DW-1:0] dvs_r;
  logic [CW-1:0] cnt;
  logic          done_r;

  assign trial = {r_r[DW-1:0], q_r[W-1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_r <= '0; dvd_r <= '0; r_r <= '0; dvs_r <= '0; cnt <= '0; done_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      if (start) begin
        q_r <= dividend; dvd_r <= dividend; dvs_r <= divisor;
        r_r <= '0; cnt <= CW'(W);
      end else if (cnt != '0) begin
        if (trial >= {1'b0, dvs_r}) begin
          r_r <= trial - {1'b0, dvs_r};
          q_r <= {q_r[W-2:0], 1'b1};
        end else begin
          r_r <= trial;
          q_r <= {q_r[W-2:0], 1'b0};
        end
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) done_r <= 1'b1;
      end
    end
  end

  assign done = done_r;
  assign quot = q_r;
  assign rem  = r_r[DW-1:0];

  AST_DIV_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (XW'(q_r) * XW'(dvs_r) + XW'(r_r[DW-1:0]) == XW'(dvd_r))); // R7
  AST_DIV_REM_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (r_r[DW-1:0] < dvs_r)); // R7
endmodule

// File: rtl/scanpos_normalizer.sv
module scanpos_normalizer #(
  parameter int LINE_W    = 13,
  parameter int HPIX_W    = 13,
  parameter int RETRY_MAX = 100
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             in_valid,
  output logic                             in_ready,
  input  logic                             in_pixel_mode,
  input  logic [LINE_W+HPIX_W-1:0]         in_raw,
  input  logic                             in_zero_retry,
  input  logic [LINE_W-1:0]                in_line_offset,
  input  logic [HPIX_W-1:0]                in_htotal,
  input  logic [HPIX_W-1:0]                in_hsync_start,
  input  logic [LINE_W-1:0]                in_vtotal,
  input  logic [LINE_W-1:0]                in_vblank_start,
  input  logic [LINE_W-1:0]                in_vblank_end,
  input  logic [LINE_W-1:0]                live_line,
  output logic                             out_valid,
  input  logic                             out_ready,
  output logic signed [LINE_W+HPIX_W+1:0]  out_vpos,
  output logic signed [HPIX_W:0]           out_hpos,
  output logic                             out_in_vblank
);
  import snp_pkg::*;

  localparam int PW = LINE_W + HPIX_W;
  localparam int SW = PW + 2;
  localparam int QW = SW - 1;
  localparam int RW = $clog2(RETRY_MAX + 1);

  snp_state_e        state;
  logic              pix_q, neg_q, vb_q;
  logic [PW-1:0]     raw_q;
  logic [LINE_W-1:0] off_q, vt_q, vbs_q, vbe_q;
  logic [HPIX_W-1:0] ht_q, hss_q;
  logic [RW-1:0]     retry_cnt;
  logic signed [SW-1:0]   vpos_q, pos, pos_mag;
  logic signed [HPIX_W:0] hpos_q;
  logic              div_start, div_done;
  logic [QW-1:0]     quot;
  logic [HPIX_W-1:0] rem;

  snp_rebase #(.LINE_W(LINE_W), .HPIX_W(HPIX_W)) u_rebase (
    .pixel_mode(pix_q), .raw(raw_q), .htotal(ht_q), .hsync_start(hss_q),
    .vtotal(vt_q), .vblank_start(vbs_q), .vblank_end(vbe_q),
    .line_offset(off_q), .pos(pos)
  );

  assign pos_mag   = pos[SW-1] ? -pos : pos;
  assign div_start = (state == ST_CALC) && pix_q;

  snp_divider #(.W(QW), .DW(HPIX_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start),
    .dividend(pos_mag[QW-1:0]), .divisor(ht_q),
    .done(div_done), .quot(quot), .rem(rem)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE; pix_q <= 1'b0; neg_q <= 1'b0; vb_q <= 1'b0;
      raw_q <= '0; off_q <= '0; vt_q <= '0; vbs_q <= '0; vbe_q <= '0;
      ht_q <= '0; hss_q <= '0; retry_cnt <= '0; vpos_q <= '0; hpos_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (in_valid) begin
          pix_q <= in_pixel_mode; raw_q <= in_raw; off_q <= in_line_offset;
          ht_q <= in_htotal; hss_q <= in_hsync_start; vt_q <= in_vtotal;
          vbs_q <= in_vblank_start; vbe_q <= in_vblank_end; retry_cnt <= '0;
          state <= (!in_pixel_mode && in_zero_retry && in_raw[LINE_W-1:0] == '0)
                   ? ST_RETRY : ST_CALC;
        end
        ST_RETRY: begin
          if (live_line != '0) begin
            raw_q <= PW'(live_line);
            state <= ST_CALC;
          end else if (retry_cnt == RW'(RETRY_MAX - 1)) begin
            state <= ST_CALC;
          end else begin
            retry_cnt <= retry_cnt + RW'(1);
          end
        end
        ST_CALC: begin
          if (pix_q) begin
            neg_q <= pos[SW-1];
            state <= ST_DIV;
          end else begin
            vpos_q <= pos; hpos_q <= '0; vb_q <= pos[SW-1];
            state  <= ST_OUT;
          end
        end
        ST_DIV: if (div_done) begin
          vpos_q <= neg_q ? -$signed({1'b0, quot}) : $signed({1'b0, quot});
          hpos_q <= neg_q ? -$signed({1'b0, rem})  : $signed({1'b0, rem});
          vb_q   <= neg_q && (quot != '0);
          state  <= ST_OUT;
        end
        ST_OUT: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign in_ready      = (state == ST_IDLE);
  assign out_valid     = (state == ST_OUT);
  assign out_vpos      = vpos_q;
  assign out_hpos      = hpos_q;
  assign out_in_vblank = vb_q;

  AST_IDLE_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid); // R1
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_vpos) && $stable(out_hpos)
                                   && $stable(out_in_vblank))); // R1
  AST_LINE_HPOS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !pix_q) |-> (out_hpos == '0)); // R4
  AST_PIXEL_HPOS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && pix_q) |-> ((out_hpos < $signed({1'b0, ht_q}))
                              && (-out_hpos < $signed({1'b0, ht_q})))); // R7
  AST_VBLANK_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_in_vblank == out_vpos[SW-1])); // R8
  AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RETRY) |-> (retry_cnt < RW'(RETRY_MAX))); // R9
endmodule

// File: tb/scanpos_normalizer_test.sv
`timescale 1ns/1ps
module scanpos_normalizer_test;
  localparam int LW = 13;
  localparam int HW = 13;
  localparam int PW = LW + HW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_pixel_mode = 1'b0, in_zero_retry = 1'b0, out_ready = 1'b0;
  logic [PW-1:0] in_raw = '0;
  logic [LW-1:0] in_line_offset = '0, in_vtotal = '0, in_vblank_start = '0, in_vblank_end = '0;
  logic [LW-1:0] live_line = '0;
  logic [HW-1:0] in_htotal = '0, in_hsync_start = '0;
  logic in_ready, out_valid, out_in_vblank;
  logic signed [PW+1:0] out_vpos;
  logic signed [HW:0]   out_hpos;

  int compared = 0, mismatched = 0, cycles = 0;
  longint q_vpos[$]; longint q_hpos[$]; bit q_vb[$]; string q_tag[$];
  logic [7:0] lfsr = 8'h5a;
  bit held = 1'b0;
  longint held_v, held_h;

  always #5 clk = ~clk;

  scanpos_normalizer uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pixel_mode(in_pixel_mode), .in_raw(in_raw), .in_zero_retry(in_zero_retry),
    .in_line_offset(in_line_offset), .in_htotal(in_htotal), .in_hsync_start(in_hsync_start),
    .in_vtotal(in_vtotal), .in_vblank_start(in_vblank_start), .in_vblank_end(in_vblank_end),
    .live_line(live_line), .out_valid(out_valid), .out_ready(out_ready),
    .out_vpos(out_vpos), .out_hpos(out_hpos), .out_in_vblank(out_in_vblank)
  );

  task automatic check(string tag, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // reference model written from the requirements
  task automatic model(bit pix, longint raw, longint off,
                       output longint v, output longint h);
    longint ht, hss, vt, vbs, vbe, p;
    ht = in_htotal; hss = in_hsync_start; vt = in_vtotal;
    vbs = in_vblank_start; vbe = in_vblank_end;
    if (!pix) begin
      p = (raw + off) % vt;                               // R2
      p = (p >= vbs) ? p - vbe : p + vt - vbe;            // R3
      v = p; h = 0;                                       // R4
    end else begin
      p = (raw > vt * ht - 1) ? vt * ht - 1 : raw;        // R5
      p = (p + ht - hss) % (vt * ht);                     // R6
      p = (p >= vbs * ht) ? p - vbe * ht : p + (vt - vbe) * ht;
      v = p / ht; h = p - v * ht;                         // R7
    end
  endtask

  task automatic send(bit pix, longint raw, bit zr, longint off, longint exp_raw, string tag);
    longint v, h;
    model(pix, exp_raw, off, v, h);
    q_vpos.push_back(v); q_hpos.push_back(h); q_vb.push_back(v < 0); q_tag.push_back(tag);
    in_pixel_mode = pix; in_raw = PW'(raw); in_zero_retry = zr; in_line_offset = LW'(off);
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (q_vpos.size() != 0) @(negedge clk);
  endtask

  // monitor: choose ready for the coming edge, then compare if a transfer happens
  always @(negedge clk) begin
    if (rst_n) begin
      if (held) begin
        check("R1 held valid", out_valid, 1);
        check("R1 held vpos", out_vpos, held_v);
        check("R1 held hpos", out_hpos, held_h);
      end
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = lfsr[0] | lfsr[3];
      held = out_valid && !out_ready;
      held_v = out_vpos; held_h = out_hpos;
      if (out_valid && out_ready) begin
        if (q_vpos.size() == 0) check("R1 unexpected result", 1, 0);
        else begin
          check({q_tag[0], " vpos"}, out_vpos, q_vpos[0]);
          check({q_tag[0], " hpos"}, out_hpos, q_hpos[0]);
          check({q_tag[0], " R8 vblank"}, out_in_vblank, q_vb[0]);
          void'(q_vpos.pop_front()); void'(q_hpos.pop_front());
          void'(q_vb.pop_front()); void'(q_tag.pop_front());
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      mismatched++; compared++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    in_htotal = 13'd100; in_hsync_start = 13'd80;
    in_vtotal = 13'd30; in_vblank_start = 13'd24; in_vblank_end = 13'd30;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset in_ready", in_ready, 1);
    check("R1 reset out_valid", out_valid, 0);

    // line mode corners
    send(0, 0, 0, 1, 0, "R2 R3 raw0 off1");
    send(0, 23, 0, 1, 23, "R3 first blank line");
    send(0, 29, 0, 1, 29, "R2 wrap off1");
    send(0, 28, 0, 2, 28, "R2 off2 wrap");
    send(0, 1, 0, 29, 1, "R2 off vtotal-1");
    send(0, 22, 0, 1, 22, "R3 last active line");
    for (int r = 0; r < 30; r++) send(0, r, 0, 2, r, "R4 line sweep");

    // pixel mode corners
    send(1, 0, 0, 0, 0, "R6 skew at frame start");
    send(1, 2380, 0, 0, 2380, "R6 R7 blank edge");
    send(1, 2379, 0, 0, 2379, "R7 just before blank");
    send(1, 5000, 0, 0, 5000, "R5 clamp");
    send(1, 2999, 0, 0, 2999, "R5 last pixel");
    send(1, 2450, 0, 0, 2450, "R7 negative remainder");
    send(1, 2975, 0, 0, 2975, "R8 zero vpos negative hpos");
    for (int r = 0; r < 3300; r += 97) send(1, r, 0, 0, r, "R7 pixel sweep");
    drain();

    // zero re-sampling
    live_line = 13'd7;
    send(0, 0, 1, 1, 7, "R9 immediate nonzero");
    drain();
    live_line = 13'd0;
    send(0, 0, 1, 1, 9, "R9 late nonzero");
    repeat (10) @(negedge clk);
    live_line = 13'd9;
    drain();
    live_line = 13'd0;
    send(0, 0, 1, 1, 0, "R9 never nonzero");
    drain();
    live_line = 13'd5;
    send(0, 4, 1, 1, 4, "R9 nonzero raw not resampled");
    send(1, 0, 1, 0, 0, "R9 ignored in pixel mode");
    drain();
    live_line = 13'd0;

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule